// File: doc/BRIEF.md
# Profiling Record Filter

This block sits at the end of a sampled-operation profiling pipeline and decides whether a finished record is kept or dropped. Each record arrives as one valid cycle that carries the operation class (load, store, branch or other), a vector of event flags gathered while the operation ran, and the latency counted from the moment sampling picked the operation. A dropped record goes no further. A kept record moves on to later stages, which are not part of this block.

Three static settings drive the decision. The first is a set of operation-class enables. The second is an event mask: every supported event it names must be present in the record. The third is a minimum latency. A record is kept only when all three tests pass. The decision comes out one cycle after the record, with a valid strobe. Two saturating counters tally the kept and dropped outcomes.

Top module: `prof_rec_filter`

## Requirements
- R1: With all three class enables low, records of every class (code 0 other, 1 load, 2 store, 3 branch on `rec_op`) pass the class test.
- R2: With one or more class enables set, a record passes the class test only if its class is load with `cfg_load_only` set, store with `cfg_store_only` set, or branch with `cfg_branch_only` set. Class 0 (other) then always fails.
- R3: Supported event flags sit at fixed bit positions: bit 1 retired (not speculative), bit 3 level-1 data refill, bit 5 translation refill, bit 7 mispredict, bit 11 misaligned. The event test passes only when every supported bit set in `cfg_event_mask` is also set in `rec_events`. For example, mask 0x0080 keeps only mispredicted records.
- R4: Mask bits at any position other than 1, 3, 5, 7 and 11 have no effect on the decision.
- R5: The latency test passes when `rec_latency` is greater than or equal to `cfg_min_latency`. An equal value passes.
- R6: For every cycle with `rec_valid` high, `dec_valid` is high in the following cycle. In any other cycle it is low. `dec_keep` is low whenever `dec_valid` is low.
- R7: `dec_keep` is high only when the class, event and latency tests all pass for that record.
- R8: `kept_count` rises by one per kept record and `dropped_count` rises by one per dropped record. Both update in the same cycle as the decision, and each holds at its all-ones value instead of wrapping.
- R9: While `rst_n` is low at a clock edge, `dec_valid`, `dec_keep` and both counters become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | A record is presented this cycle |
| rec_op | input | 2 | Operation class: 0 other, 1 load, 2 store, 3 branch |
| rec_events | input | EVT_W (16) | Event flags of the record |
| rec_latency | input | LAT_W (16) | Latency counted from the start of sampling |
| cfg_load_only | input | 1 | Admit load records |
| cfg_store_only | input | 1 | Admit store records |
| cfg_branch_only | input | 1 | Admit branch records |
| cfg_event_mask | input | EVT_W (16) | Events that must be present |
| cfg_min_latency | input | LAT_W (16) | Minimum latency to keep |
| dec_valid | output | 1 | Decision strobe, one cycle after the record |
| dec_keep | output | 1 | Record is kept (meaningful with dec_valid) |
| kept_count | output | CNT_W (32) | Saturating count of kept records |
| dropped_count | output | CNT_W (32) | Saturating count of dropped records |

## Verification
The bench targets latency exactly equal to the threshold; a design that compared strictly would drop those records. It tries an "other" class record while some class enable is set, and several enables set at once; a design that treated the enables as a required match, or that let any class through, would fail these cases. It sets mask bits outside the five supported positions; a design that did not ignore them would drop records it should keep. A second instance with 3-bit counters is driven past seven of each outcome, so a counter that wraps would read a small value.

// File: rtl/prf_pkg.sv
// Package: shared operation-class encoding and supported-event positions
// for the profiling record filter.
package prf_pkg;
    typedef enum logic [1:0] {
        OPC_OTHER  = 2'd0,
        OPC_LOAD   = 2'd1,
        OPC_STORE  = 2'd2,
        OPC_BRANCH = 2'd3
    } opclass_e;

    // Fixed positions of the filterable event flags.
    localparam int EV_RETIRED    = 1;
    localparam int EV_L1D_REFILL = 3;
    localparam int EV_TLB_REFILL = 5;
    localparam int EV_MISPREDICT = 7;
    localparam int EV_MISALIGNED = 11;

    // True when bit position p is one of the filterable events.
    function automatic logic is_supported_event(input int p);
        return (p == EV_RETIRED) || (p == EV_L1D_REFILL) || (p == EV_TLB_REFILL) ||
               (p == EV_MISPREDICT) || (p == EV_MISALIGNED);
    endfunction
endpackage

// File: rtl/prf_class_match.sv
// Class test: passes when no class enable is set, or when the record's
// class matches any enabled class. Purely combinational.
// Assumes rec_op follows the prf_pkg opclass_e encoding.
module prf_class_match
    import prf_pkg::*;
(
    input  logic [1:0] rec_op,
    input  logic       en_load,
    input  logic       en_store,
    input  logic       en_branch,
    output logic       pass
);
    logic any_en;
    logic hit;

    // Decide whether the record's class is admitted.
    always_comb begin
        any_en = en_load | en_store | en_branch;
        hit    = (en_load   && (rec_op == OPC_LOAD))  ||
                 (en_store  && (rec_op == OPC_STORE)) ||
                 (en_branch && (rec_op == OPC_BRANCH));
        pass   = !any_en || hit;
    end
endmodule

// File: rtl/prf_event_match.sv
// Event test: every supported bit set in the mask must also be set in the
// record's event vector. Unsupported mask positions are forced out.
// Assumes EVT_W >= 12 so all supported positions exist.
module prf_event_match
    import prf_pkg::*;
#(
    parameter int EVT_W = 16
) (
    input  logic [EVT_W-1:0] events,
    input  logic [EVT_W-1:0] mask,
    output logic             pass
);
    logic [EVT_W-1:0] supported;
    logic [EVT_W-1:0] missing;

    // One constant bit per position marking the filterable events.
    for (genvar i = 0; i < EVT_W; i++) begin : g_supp
        assign supported[i] = is_supported_event(i);
    end

    // A required, supported event that is absent fails the test.
    always_comb begin
        missing = mask & supported & ~events;
        pass    = (missing == '0);
    end
endmodule

// File: rtl/prf_sat_counter.sv
// Saturating up-counter: adds one per increment pulse and holds at all-ones.
// Synchronous active-low reset clears it.
module prf_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    // Count up on inc, stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (inc && (value != TOP))
            value <= value + 1'b1;
    end

    // R8: the counter never wraps from the top value.
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(value) == TOP) |-> (value == TOP));
    // R8: the counter moves only by a single step on an increment.
    a_r8_step_only_on_inc: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(inc) |-> (value == $past(value)));
endmodule

// File: rtl/prof_rec_filter.sv
// Profiling record filter top. It combines the class, event and latency
// tests into a registered keep/drop decision one cycle after the record,
// and keeps saturating tallies of both outcomes.
// Assumes configuration is stable while records are presented.
module prof_rec_filter
    import prf_pkg::*;
#(
    parameter int EVT_W = 16,
    parameter int LAT_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    input  logic [1:0]       rec_op,
    input  logic [EVT_W-1:0] rec_events,
    input  logic [LAT_W-1:0] rec_latency,
    input  logic             cfg_load_only,
    input  logic             cfg_store_only,
    input  logic             cfg_branch_only,
    input  logic [EVT_W-1:0] cfg_event_mask,
    input  logic [LAT_W-1:0] cfg_min_latency,
    output logic             dec_valid,
    output logic             dec_keep,
    output logic [CNT_W-1:0] kept_count,
    output logic [CNT_W-1:0] dropped_count
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic class_ok;
    logic event_ok;
    logic lat_ok;
    logic keep_now;

    prf_class_match u_class (
        .rec_op    (rec_op),
        .en_load   (cfg_load_only),
        .en_store  (cfg_store_only),
        .en_branch (cfg_branch_only),
        .pass      (class_ok)
    );

    prf_event_match #(.EVT_W(EVT_W)) u_event (
        .events (rec_events),
        .mask   (cfg_event_mask),
        .pass   (event_ok)
    );

    // Latency test and combined verdict for the presented record.
    always_comb begin
        lat_ok   = (rec_latency >= cfg_min_latency);
        keep_now = class_ok && event_ok && lat_ok;
    end

    // Register the decision and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_keep  <= 1'b0;
        end else begin
            dec_valid <= rec_valid;
            dec_keep  <= rec_valid && keep_now;
        end
    end

    prf_sat_counter #(.W(CNT_W)) u_kept (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rec_valid && keep_now),
        .value (kept_count)
    );

    prf_sat_counter #(.W(CNT_W)) u_dropped (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rec_valid && !keep_now),
        .value (dropped_count)
    );

    // R6: each record yields a decision strobe on the next cycle.
    a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> dec_valid);
    // R6: no strobe without a record in the previous cycle.
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |=> !dec_valid);
    // R6: keep is low whenever the strobe is low.
    a_r6_keep_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_keep);
    // R5: a record below the latency threshold is never kept.
    a_r5_below_min_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && (rec_latency < cfg_min_latency)) |=> !dec_keep);
    // R2: an "other" record is dropped once any class enable is set.
    a_r2_other_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && (rec_op == OPC_OTHER) &&
         (cfg_load_only || cfg_store_only || cfg_branch_only)) |=> !dec_keep);
    // R8: a kept decision advances the kept tally unless it is saturated.
    a_r8_kept_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_keep && ($past(kept_count) != CNT_TOP)) |->
        (kept_count == $past(kept_count) + 1'b1));
    // R8: a kept decision leaves the dropped tally untouched.
    a_r8_dropped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_keep) |-> $stable(dropped_count));
endmodule

// File: tb/prof_rec_filter_test.sv
// Self-checking bench: directed corner cases plus seeded random records,
// compared against a model built from the requirements.
module prof_rec_filter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rec_valid;
    logic [1:0]  rec_op;
    logic [15:0] rec_events;
    logic [15:0] rec_latency;
    logic        cfg_load_only, cfg_store_only, cfg_branch_only;
    logic [15:0] cfg_event_mask;
    logic [15:0] cfg_min_latency;
    logic        dec_valid, dec_keep;
    logic [31:0] kept_count, dropped_count;
    logic        s_valid, s_keep;
    logic [2:0]  s_kept, s_dropped;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    longint m_kept = 0;
    longint m_dropped = 0;

    always #10 clk = ~clk;

    prof_rec_filter uut (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_op(rec_op),
        .rec_events(rec_events), .rec_latency(rec_latency),
        .cfg_load_only(cfg_load_only), .cfg_store_only(cfg_store_only),
        .cfg_branch_only(cfg_branch_only), .cfg_event_mask(cfg_event_mask),
        .cfg_min_latency(cfg_min_latency), .dec_valid(dec_valid),
        .dec_keep(dec_keep), .kept_count(kept_count), .dropped_count(dropped_count)
    );

    prof_rec_filter #(.CNT_W(3)) uut_sat (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_op(rec_op),
        .rec_events(rec_events), .rec_latency(rec_latency),
        .cfg_load_only(cfg_load_only), .cfg_store_only(cfg_store_only),
        .cfg_branch_only(cfg_branch_only), .cfg_event_mask(cfg_event_mask),
        .cfg_min_latency(cfg_min_latency), .dec_valid(s_valid),
        .dec_keep(s_keep), .kept_count(s_kept), .dropped_count(s_dropped)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected verdict from R1..R5 and R7.
    function automatic bit model_keep(input logic [1:0] op, input logic [15:0] ev,
                                      input logic [15:0] lat);
        bit any_en = cfg_load_only | cfg_store_only | cfg_branch_only;
        bit cls = !any_en || (cfg_load_only && op == 2'd1) ||
                  (cfg_store_only && op == 2'd2) || (cfg_branch_only && op == 2'd3);
        logic [15:0] need = cfg_event_mask & 16'h08AA;
        bit evt = ((need & ~ev) == 16'h0);
        bit lt = (lat >= cfg_min_latency);
        return cls && evt && lt;
    endfunction

    task automatic set_cfg(input bit l, input bit s, input bit b,
                           input logic [15:0] m, input logic [15:0] minl);
        cfg_load_only = l; cfg_store_only = s; cfg_branch_only = b;
        cfg_event_mask = m; cfg_min_latency = minl;
    endtask

    // Present one record, then check the decision and tallies after the edge.
    task automatic send(input logic [1:0] op, input logic [15:0] ev,
                        input logic [15:0] lat, input string req);
        bit exp;
        @(negedge clk);
        rec_op = op; rec_events = ev; rec_latency = lat; rec_valid = 1'b1;
        exp = model_keep(op, ev, lat);
        @(posedge clk);
        #5;
        rec_valid = 1'b0;
        if (exp) m_kept++; else m_dropped++;
        check(dec_valid == 1'b1, "R6", "dec_valid after record", dec_valid, 1);
        check(dec_keep == exp, req, "dec_keep", dec_keep, exp);
        check(kept_count == m_kept, "R8", "kept_count", kept_count, m_kept);
        check(dropped_count == m_dropped, "R8", "dropped_count", dropped_count, m_dropped);
        check(s_kept == ((m_kept > 7) ? 7 : m_kept), "R8", "saturating kept",
              s_kept, (m_kept > 7) ? 7 : m_kept);
        check(s_dropped == ((m_dropped > 7) ? 7 : m_dropped), "R8", "saturating dropped",
              s_dropped, (m_dropped > 7) ? 7 : m_dropped);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; rec_valid = 1'b1; rec_op = 2'd1;
        rec_events = 16'hFFFF; rec_latency = 16'hFFFF;
        set_cfg(0, 0, 0, 16'h0, 16'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state even with a record applied during reset.
        check(dec_valid == 0, "R9", "dec_valid in reset", dec_valid, 0);
        check(dec_keep == 0, "R9", "dec_keep in reset", dec_keep, 0);
        check(kept_count == 0, "R9", "kept_count in reset", kept_count, 0);
        check(dropped_count == 0, "R9", "dropped_count in reset", dropped_count, 0);
        rec_valid = 1'b0;
        rst_n = 1'b1;

        // R1: no class enables, every class passes.
        for (int op = 0; op < 4; op++) send(op[1:0], 16'h0, 16'd5, "R1");

        // R6: idle cycle gives no strobe.
        @(posedge clk); #5;
        check(dec_valid == 0, "R6", "dec_valid idle", dec_valid, 0);
        check(dec_keep == 0, "R6", "dec_keep idle", dec_keep, 0);

        // R2: single and combined class enables, "other" rejected.
        set_cfg(1, 0, 0, 16'h0, 16'h0);
        send(2'd1, 16'h0, 16'd0, "R2");
        send(2'd2, 16'h0, 16'd0, "R2");
        send(2'd0, 16'h0, 16'd0, "R2");
        set_cfg(0, 1, 1, 16'h0, 16'h0);
        send(2'd2, 16'h0, 16'd0, "R2");
        send(2'd3, 16'h0, 16'd0, "R2");
        send(2'd1, 16'h0, 16'd0, "R2");
        send(2'd0, 16'h0, 16'd0, "R2");

        // R3: mispredict-only mask and multi-event mask.
        set_cfg(0, 0, 0, 16'h0080, 16'h0);
        send(2'd3, 16'h0080, 16'd1, "R3");
        send(2'd3, 16'h0002, 16'd1, "R3");
        set_cfg(0, 0, 0, 16'h0822, 16'h0);
        send(2'd1, 16'h0822, 16'd1, "R3");
        send(2'd1, 16'h0820, 16'd1, "R3");

        // R4: unsupported mask bits ignored.
        set_cfg(0, 0, 0, 16'hF755, 16'h0);
        send(2'd1, 16'h0000, 16'd1, "R4");
        set_cfg(0, 0, 0, 16'hF7D5, 16'h0);
        send(2'd1, 16'h0080, 16'd1, "R4");

        // R5: threshold boundary.
        set_cfg(0, 0, 0, 16'h0, 16'd100);
        send(2'd1, 16'h0, 16'd99, "R5");
        send(2'd1, 16'h0, 16'd100, "R5");
        send(2'd1, 16'h0, 16'd101, "R5");
        set_cfg(0, 0, 0, 16'h0, 16'hFFFF);
        send(2'd1, 16'h0, 16'hFFFF, "R5");

        // R7: all tests must agree; one failing test drops.
        set_cfg(0, 0, 1, 16'h0080, 16'd10);
        send(2'd3, 16'h0080, 16'd10, "R7");
        send(2'd3, 16'h0080, 16'd9, "R7");
        send(2'd3, 16'h0000, 16'd10, "R7");
        send(2'd1, 16'h0080, 16'd10, "R7");

        // R7: seeded random records and configurations.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] mk;
            if (n % 20 == 0) begin
                mk = 16'($urandom) & (($urandom % 2) ? 16'h08AA : 16'hFFFF);
                if ($urandom % 3 == 0) mk = 16'h0;
                set_cfg(1'($urandom), 1'($urandom), 1'($urandom), mk,
                        16'($urandom % 64));
            end
            send(2'($urandom), 16'($urandom) | 16'($urandom), 16'($urandom % 80), "R7");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule